// File: doc/BRIEF.md
# Control Endpoint SETUP Capture

This block sits between the packet layer of a USB device function and the firmware, and handles the SETUP stage of control transfers on endpoint zero. The packet layer hands it decoded events: a token strobe with its kind, an address-match flag and the endpoint number, then the data bytes one per strobe, and finally an end-of-packet strobe that says whether the packet arrived intact. When the token is a SETUP addressed to endpoint zero of this device and the function is enabled, the block collects the following data bytes into a shadow buffer.

A packet that ends cleanly with exactly the expected request length is committed to a bank of readable request registers. The block then asks the packet layer for an ACK handshake and raises a sticky status flag. It also parks endpoint zero: both directions are forced to NAK, any stall is removed and the data toggle is set. Firmware decodes the request and releases each direction by clearing its force-NAK bit. A packet that fails in any way leaves no trace: there is no handshake and no status, and the request registers keep the previous request.

Top module: `ep0_setup_capture`

## Requirements
- R1: Only a token with kind SETUP (tok_kind = 2'b10; 2'b00 is OUT, 2'b01 is IN, 2'b11 is any other) arms capture, and only while func_en is high, tok_addr_hit is high and tok_ep equals 0. A packet after any other token causes no handshake, no status change and no register change.
- R2: The data bytes after an arming token are stored in arrival order. The first byte goes to request index 0 and the eighth to index 7. Each index can be read on fw_rd_data by placing it on fw_rd_idx.
- R3: After a good packet, hs_ack is high for exactly one cycle, in the cycle that follows the clock edge sampling rx_eop. The request bytes become readable and stat_setup rises in that same cycle.
- R4: A packet that ends with rx_eop_ok low, or that carries fewer or more than 8 bytes, is an error. It produces no hs_ack and no stat_setup, and the request registers keep their earlier contents.
- R5: A good SETUP sets both ep0_nak_in and ep0_nak_out.
- R6: A good SETUP clears ep0_stall and sets ep0_toggle.
- R7: A pulse on fw_clr_nak_in clears only ep0_nak_in, and a pulse on fw_clr_nak_out clears only ep0_nak_out, one cycle later. If a good SETUP completes in the same cycle, the NAK bit stays set.
- R8: stat_setup stays set until a pulse on fw_stat_w1c clears it. irq is high exactly while stat_setup and irq_en are both high.
- R9: After reset, every request register reads 0 and stat_setup, irq, hs_ack, ep0_nak_in, ep0_nak_out, ep0_stall and ep0_toggle are all 0.
- R10: A pulse on fw_set_stall sets ep0_stall on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| func_en | input | 1 | Device function enabled |
| tok_valid | input | 1 | Token event strobe |
| tok_kind | input | 2 | Token kind: 00 OUT, 01 IN, 10 SETUP, 11 other |
| tok_addr_hit | input | 1 | Token address matches this device |
| tok_ep | input | EP_W (4) | Token endpoint number |
| rx_byte_valid | input | 1 | Data byte strobe |
| rx_byte | input | DATA_W (8) | Data byte |
| rx_eop | input | 1 | End-of-packet strobe |
| rx_eop_ok | input | 1 | Packet intact (CRC and framing good), valid with rx_eop |
| hs_ack | output | 1 | Request to send an ACK handshake |
| fw_rd_idx | input | IDX_W (3) | Request byte index to read |
| fw_rd_data | output | DATA_W (8) | Request byte at fw_rd_idx |
| fw_clr_nak_in | input | 1 | Clear the IN force-NAK bit |
| fw_clr_nak_out | input | 1 | Clear the OUT force-NAK bit |
| fw_set_stall | input | 1 | Set the endpoint-zero stall bit |
| fw_stat_w1c | input | 1 | Clear the SETUP-received status |
| irq_en | input | 1 | Interrupt enable for the status |
| stat_setup | output | 1 | SETUP-received status, sticky |
| irq | output | 1 | Interrupt request |
| ep0_nak_in | output | 1 | Force NAK on the IN direction |
| ep0_nak_out | output | 1 | Force NAK on the OUT direction |
| ep0_stall | output | 1 | Endpoint-zero stall |
| ep0_toggle | output | 1 | Data toggle status |

## Verification
Every result of a completed SETUP is due one clock edge after the edge that samples rx_eop. This covers the handshake, the committed request bytes, the status flag and the endpoint-zero control bits. The handshake must drop again one edge later. Firmware pulses take effect one edge after they are sampled. The read port is combinational, so a byte is read a short delay after its index is set. The bench drives every input on the falling clock edge and samples at the next falling edge, exactly one rising edge later. A table of token and packet variants is walked with a running model of the request bank. Each vector is preceded by setting stall and clearing NAK and status, so every bit a SETUP should change is seen to change, or seen to stay put.

// File: rtl/ep0_setup_pkg.sv
package ep0_setup_pkg;

   typedef enum logic [1:0] {
      TOK_OUT   = 2'b00,
      TOK_IN    = 2'b01,
      TOK_SETUP = 2'b10,
      TOK_OTHER = 2'b11
   } tok_kind_e;

   typedef enum logic {
      CAP_IDLE = 1'b0,
      CAP_DATA = 1'b1
   } cap_state_e;

endpackage

// File: rtl/setup_rx_fsm.sv
module setup_rx_fsm
   import ep0_setup_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SETUP_BYTES = 8,
   parameter int EP_W        = 4,
   parameter int CTRL_EP     = 0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          func_en,
   input  logic                          tok_valid,
   input  logic [1:0]                    tok_kind,
   input  logic                          tok_addr_hit,
   input  logic [EP_W-1:0]               tok_ep,
   input  logic                          rx_byte_valid,
   input  logic [DATA_W-1:0]             rx_byte,
   input  logic                          rx_eop,
   input  logic                          rx_eop_ok,
   output logic                          commit,
   output logic [SETUP_BYTES*DATA_W-1:0] shadow_flat
);

   localparam int CNT_W = $clog2(SETUP_BYTES + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(SETUP_BYTES);
   localparam logic [EP_W-1:0]  EP_ZERO = EP_W'(CTRL_EP);

   cap_state_e       state;
   logic [CNT_W-1:0] cnt;
   logic             ovf;
   logic             arm;
   logic             byte_take;

   // SETUP token aimed at the control endpoint of this enabled device
   assign arm = func_en && tok_valid && (tok_kind_e'(tok_kind) == TOK_SETUP)
                && tok_addr_hit && (tok_ep == EP_ZERO);

   // a byte counts only inside an armed packet and never together with a token or EOP
   assign byte_take = (state == CAP_DATA) && func_en && !tok_valid && !rx_eop && rx_byte_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= CAP_IDLE;
         cnt   <= '0;
         ovf   <= 1'b0;
      end else if (arm) begin
         state <= CAP_DATA;
         cnt   <= '0;
         ovf   <= 1'b0;
      end else if (tok_valid || !func_en) begin
         state <= CAP_IDLE;
      end else if (state == CAP_DATA) begin
         if (rx_eop) begin
            state <= CAP_IDLE;
         end else if (rx_byte_valid) begin
            if (cnt == FULL) ovf <= 1'b1;
            else             cnt <= cnt + 1'b1;
         end
      end
   end

   // one shadow slot per request byte, loaded while its index is current
   for (genvar g = 0; g < SETUP_BYTES; g++) begin : g_shadow
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            shadow_flat[g*DATA_W +: DATA_W] <= '0;
         end else if (byte_take && (cnt == CNT_W'(g))) begin
            shadow_flat[g*DATA_W +: DATA_W] <= rx_byte;
         end
      end
   end

   assign commit = (state == CAP_DATA) && func_en && !tok_valid && rx_eop
                   && rx_eop_ok && (cnt == FULL) && !ovf;

   AST_ARM_STARTS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      arm |=> (state == CAP_DATA) && (cnt == '0) && !ovf); // R1

   AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= FULL); // R2

   AST_EOP_ENDS_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
      (state == CAP_DATA && rx_eop && !tok_valid) |=> (state == CAP_IDLE)); // R4

   AST_COMMIT_FROM_IDLE_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> !commit); // R4

endmodule

// File: rtl/setup_reg_bank.sv
module setup_reg_bank #(
   parameter int DATA_W      = 8,
   parameter int SETUP_BYTES = 8,
   parameter bit RD_REG      = 1'b0,
   localparam int IDX_W      = (SETUP_BYTES > 1) ? $clog2(SETUP_BYTES) : 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          commit,
   input  logic [SETUP_BYTES*DATA_W-1:0] shadow_flat,
   input  logic [IDX_W-1:0]              rd_idx,
   output logic [DATA_W-1:0]             rd_data
);

   logic [SETUP_BYTES*DATA_W-1:0] regs_flat;
   logic [DATA_W-1:0]             rd_sel;

   for (genvar g = 0; g < SETUP_BYTES; g++) begin : g_bank
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            regs_flat[g*DATA_W +: DATA_W] <= '0;
         end else if (commit) begin
            regs_flat[g*DATA_W +: DATA_W] <= shadow_flat[g*DATA_W +: DATA_W];
         end
      end
   end

   always_comb begin
      rd_sel = '0;
      for (int i = 0; i < SETUP_BYTES; i++) begin
         if (rd_idx == IDX_W'(i)) rd_sel = regs_flat[i*DATA_W +: DATA_W];
      end
   end

   if (RD_REG) begin : g_rd_reg
      always_ff @(posedge clk) begin
         if (!rst_n) rd_data <= '0;
         else        rd_data <= rd_sel;
      end
   end else begin : g_rd_comb
      assign rd_data = rd_sel;
   end

   AST_REGS_HOLD_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(regs_flat)); // R4

   AST_REGS_TAKE_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (regs_flat == $past(shadow_flat))); // R2

endmodule

// File: rtl/ep0_ctrl_bits.sv
module ep0_ctrl_bits (
   input  logic clk,
   input  logic rst_n,
   input  logic commit,
   input  logic fw_clr_nak_in,
   input  logic fw_clr_nak_out,
   input  logic fw_set_stall,
   input  logic fw_stat_w1c,
   input  logic irq_en,
   output logic stat_setup,
   output logic irq,
   output logic nak_in,
   output logic nak_out,
   output logic stall,
   output logic toggle
);

   // a completing SETUP outranks any firmware write in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_setup <= 1'b0;
         nak_in     <= 1'b0;
         nak_out    <= 1'b0;
         stall      <= 1'b0;
         toggle     <= 1'b0;
      end else if (commit) begin
         stat_setup <= 1'b1;
         nak_in     <= 1'b1;
         nak_out    <= 1'b1;
         stall      <= 1'b0;
         toggle     <= 1'b1;
      end else begin
         if (fw_stat_w1c)    stat_setup <= 1'b0;
         if (fw_clr_nak_in)  nak_in     <= 1'b0;
         if (fw_clr_nak_out) nak_out    <= 1'b0;
         if (fw_set_stall)   stall      <= 1'b1;
      end
   end

   assign irq = stat_setup & irq_en;

   AST_COMMIT_NAK_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> nak_in && nak_out); // R5

   AST_COMMIT_STALL_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> !stall && toggle); // R6

   AST_CLR_NAK_IN: assert property (@(posedge clk) disable iff (!rst_n)
      (fw_clr_nak_in && !commit) |=> !nak_in); // R7

   AST_CLR_NAK_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      (fw_clr_nak_out && !commit) |=> !nak_out); // R7

   AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_setup && !fw_stat_w1c) |=> stat_setup); // R8

   AST_SET_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (fw_set_stall && !commit) |=> stall); // R10

endmodule

// File: rtl/ep0_setup_capture.sv
module ep0_setup_capture #(
   parameter int DATA_W      = 8,
   parameter int SETUP_BYTES = 8,
   parameter int EP_W        = 4,
   parameter int CTRL_EP     = 0,
   parameter bit RD_REG      = 1'b0,
   localparam int IDX_W      = (SETUP_BYTES > 1) ? $clog2(SETUP_BYTES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              func_en,
   input  logic              tok_valid,
   input  logic [1:0]        tok_kind,
   input  logic              tok_addr_hit,
   input  logic [EP_W-1:0]   tok_ep,
   input  logic              rx_byte_valid,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              rx_eop,
   input  logic              rx_eop_ok,
   output logic              hs_ack,
   input  logic [IDX_W-1:0]  fw_rd_idx,
   output logic [DATA_W-1:0] fw_rd_data,
   input  logic              fw_clr_nak_in,
   input  logic              fw_clr_nak_out,
   input  logic              fw_set_stall,
   input  logic              fw_stat_w1c,
   input  logic              irq_en,
   output logic              stat_setup,
   output logic              irq,
   output logic              ep0_nak_in,
   output logic              ep0_nak_out,
   output logic              ep0_stall,
   output logic              ep0_toggle
);

   if (DATA_W < 1) begin : g_chk_data_w
      $error("DATA_W must be at least 1");
   end
   if (SETUP_BYTES < 1) begin : g_chk_bytes
      $error("SETUP_BYTES must be at least 1");
   end
   if (EP_W < 1 || CTRL_EP < 0 || CTRL_EP >= (1 << EP_W)) begin : g_chk_ep
      $error("CTRL_EP must fit in EP_W bits");
   end

   logic                          commit;
   logic [SETUP_BYTES*DATA_W-1:0] shadow_flat;

   setup_rx_fsm #(
      .DATA_W      (DATA_W),
      .SETUP_BYTES (SETUP_BYTES),
      .EP_W        (EP_W),
      .CTRL_EP     (CTRL_EP)
   ) i_rx_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .func_en       (func_en),
      .tok_valid     (tok_valid),
      .tok_kind      (tok_kind),
      .tok_addr_hit  (tok_addr_hit),
      .tok_ep        (tok_ep),
      .rx_byte_valid (rx_byte_valid),
      .rx_byte       (rx_byte),
      .rx_eop        (rx_eop),
      .rx_eop_ok     (rx_eop_ok),
      .commit        (commit),
      .shadow_flat   (shadow_flat)
   );

   setup_reg_bank #(
      .DATA_W      (DATA_W),
      .SETUP_BYTES (SETUP_BYTES),
      .RD_REG      (RD_REG)
   ) i_reg_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .commit      (commit),
      .shadow_flat (shadow_flat),
      .rd_idx      (fw_rd_idx),
      .rd_data     (fw_rd_data)
   );

   ep0_ctrl_bits i_ctrl_bits (
      .clk            (clk),
      .rst_n          (rst_n),
      .commit         (commit),
      .fw_clr_nak_in  (fw_clr_nak_in),
      .fw_clr_nak_out (fw_clr_nak_out),
      .fw_set_stall   (fw_set_stall),
      .fw_stat_w1c    (fw_stat_w1c),
      .irq_en         (irq_en),
      .stat_setup     (stat_setup),
      .irq            (irq),
      .nak_in         (ep0_nak_in),
      .nak_out        (ep0_nak_out),
      .stall          (ep0_stall),
      .toggle         (ep0_toggle)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) hs_ack <= 1'b0;
      else        hs_ack <= commit;
   end

   AST_ACK_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      hs_ack |=> !hs_ack); // R3

   AST_ACK_FOLLOWS_EOP: assert property (@(posedge clk) disable iff (!rst_n)
      hs_ack |-> $past(rx_eop) && $past(rx_eop_ok)); // R4

   AST_ACK_WITH_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      hs_ack |-> stat_setup && ep0_nak_in && ep0_nak_out); // R3

endmodule

// File: tb/test_ep0_setup_capture.sv
module test_ep0_setup_capture;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       func_en, tok_valid, tok_addr_hit;
   logic [1:0] tok_kind;
   logic [3:0] tok_ep;
   logic       rx_byte_valid, rx_eop, rx_eop_ok;
   logic [7:0] rx_byte;
   logic       hs_ack;
   logic [2:0] fw_rd_idx;
   logic [7:0] fw_rd_data;
   logic       fw_clr_nak_in, fw_clr_nak_out, fw_set_stall, fw_stat_w1c, irq_en;
   logic       stat_setup, irq, ep0_nak_in, ep0_nak_out, ep0_stall, ep0_toggle;

   int  checks = 0;
   int  errors = 0;
   bit  done   = 1'b0;

   logic [7:0] model [8];
   logic       exp_toggle;

   always #5 clk = ~clk;

   ep0_setup_capture i_ep0_setup_capture (
      .clk            (clk),
      .rst_n          (rst_n),
      .func_en        (func_en),
      .tok_valid      (tok_valid),
      .tok_kind       (tok_kind),
      .tok_addr_hit   (tok_addr_hit),
      .tok_ep         (tok_ep),
      .rx_byte_valid  (rx_byte_valid),
      .rx_byte        (rx_byte),
      .rx_eop         (rx_eop),
      .rx_eop_ok      (rx_eop_ok),
      .hs_ack         (hs_ack),
      .fw_rd_idx      (fw_rd_idx),
      .fw_rd_data     (fw_rd_data),
      .fw_clr_nak_in  (fw_clr_nak_in),
      .fw_clr_nak_out (fw_clr_nak_out),
      .fw_set_stall   (fw_set_stall),
      .fw_stat_w1c    (fw_stat_w1c),
      .irq_en         (irq_en),
      .stat_setup     (stat_setup),
      .irq            (irq),
      .ep0_nak_in     (ep0_nak_in),
      .ep0_nak_out    (ep0_nak_out),
      .ep0_stall      (ep0_stall),
      .ep0_toggle     (ep0_toggle)
   );

   typedef struct packed {
      logic       en;
      logic [1:0] kind;
      logic       hit;
      logic [3:0] ep;
      logic [3:0] nbytes;
      logic       ok;
      logic [7:0] base;
      logic       ack;
   } vec_t;

   localparam int NVEC = 9;
   localparam vec_t VECS [NVEC] = '{
      '{1'b1, 2'b10, 1'b1, 4'd0, 4'd8, 1'b1, 8'h10, 1'b1},  // good SETUP
      '{1'b0, 2'b10, 1'b1, 4'd0, 4'd8, 1'b1, 8'h20, 1'b0},  // function off
      '{1'b1, 2'b10, 1'b0, 4'd0, 4'd8, 1'b1, 8'h30, 1'b0},  // other address
      '{1'b1, 2'b10, 1'b1, 4'd1, 4'd8, 1'b1, 8'h40, 1'b0},  // endpoint 1
      '{1'b1, 2'b00, 1'b1, 4'd0, 4'd8, 1'b1, 8'h50, 1'b0},  // OUT token
      '{1'b1, 2'b10, 1'b1, 4'd0, 4'd8, 1'b0, 8'h60, 1'b0},  // bad packet
      '{1'b1, 2'b10, 1'b1, 4'd0, 4'd7, 1'b1, 8'h70, 1'b0},  // short
      '{1'b1, 2'b10, 1'b1, 4'd0, 4'd9, 1'b1, 8'h80, 1'b0},  // long
      '{1'b1, 2'b10, 1'b1, 4'd0, 4'd8, 1'b1, 8'hA0, 1'b1}   // good again
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      tok_valid = 1'b0; tok_kind = 2'b11; tok_addr_hit = 1'b0; tok_ep = '0;
      rx_byte_valid = 1'b0; rx_byte = '0; rx_eop = 1'b0; rx_eop_ok = 1'b0;
      fw_clr_nak_in = 1'b0; fw_clr_nak_out = 1'b0; fw_set_stall = 1'b0; fw_stat_w1c = 1'b0;
   endtask

   task automatic fw_pulse(input bit clr_in, input bit clr_out, input bit set_stall, input bit w1c);
      @(negedge clk);
      fw_clr_nak_in = clr_in; fw_clr_nak_out = clr_out;
      fw_set_stall = set_stall; fw_stat_w1c = w1c;
      @(negedge clk);
      fw_clr_nak_in = 1'b0; fw_clr_nak_out = 1'b0;
      fw_set_stall = 1'b0; fw_stat_w1c = 1'b0;
   endtask

   // token, bytes, then EOP held one cycle; returns at the falling edge after the EOP edge
   task automatic send_packet(input logic [1:0] kind, input logic hit, input logic [3:0] ep,
                              input int nbytes, input logic ok, input logic [7:0] base,
                              input bit clr_in_with_eop);
      @(negedge clk);
      tok_valid = 1'b1; tok_kind = kind; tok_addr_hit = hit; tok_ep = ep;
      @(negedge clk);
      tok_valid = 1'b0;
      for (int i = 0; i < nbytes; i++) begin
         rx_byte_valid = 1'b1; rx_byte = base + 8'(i);
         @(negedge clk);
      end
      rx_byte_valid = 1'b0;
      rx_eop = 1'b1; rx_eop_ok = ok; fw_clr_nak_in = clr_in_with_eop;
      @(negedge clk);
      rx_eop = 1'b0; rx_eop_ok = 1'b0; fw_clr_nak_in = 1'b0;
   endtask

   task automatic check_bank(input string req);
      for (int i = 0; i < 8; i++) begin
         fw_rd_idx = 3'(i);
         #1;
         check(req, {24'd0, fw_rd_data}, {24'd0, model[i]});
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; func_en = 1'b1; irq_en = 1'b0; fw_rd_idx = '0;
      idle_inputs();
      for (int i = 0; i < 8; i++) model[i] = '0;
      exp_toggle = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R9: reset state
      check("R9 hs_ack", {31'd0, hs_ack}, 0);
      check("R9 stat", {31'd0, stat_setup}, 0);
      check("R9 irq", {31'd0, irq}, 0);
      check("R9 naks", {30'd0, ep0_nak_in, ep0_nak_out}, 0);
      check("R9 stall/toggle", {30'd0, ep0_stall, ep0_toggle}, 0);
      check_bank("R9 bank");

      // table walk: R1 R2 R3 R4 R5 R6
      for (int v = 0; v < NVEC; v++) begin
         func_en = VECS[v].en;
         fw_pulse(1'b1, 1'b1, 1'b1, 1'b1);
         send_packet(VECS[v].kind, VECS[v].hit, VECS[v].ep, int'(VECS[v].nbytes),
                     VECS[v].ok, VECS[v].base, 1'b0);
         if (VECS[v].ack) begin
            for (int i = 0; i < 8; i++) model[i] = VECS[v].base + 8'(i);
            exp_toggle = 1'b1;
         end
         check(VECS[v].ack ? "R3 ack" : "R1/R4 no ack", {31'd0, hs_ack}, {31'd0, VECS[v].ack});
         check(VECS[v].ack ? "R3 stat" : "R4 no stat", {31'd0, stat_setup}, {31'd0, VECS[v].ack});
         check("R5 naks", {30'd0, ep0_nak_in, ep0_nak_out}, VECS[v].ack ? 32'd3 : 32'd0);
         check("R6 stall", {31'd0, ep0_stall}, {31'd0, !VECS[v].ack});
         check("R6 toggle", {31'd0, ep0_toggle}, {31'd0, exp_toggle});
         check_bank(VECS[v].ack ? "R2 bank" : "R4 bank kept");
         @(negedge clk);
         check("R3 ack one cycle", {31'd0, hs_ack}, 0);
      end
      func_en = 1'b1;

      // R10: stall set by firmware
      fw_pulse(1'b0, 1'b0, 1'b1, 1'b0);
      check("R10 stall set", {31'd0, ep0_stall}, 1);

      // R7: per-direction release
      fw_pulse(1'b1, 1'b0, 1'b0, 1'b0);
      check("R7 clr in", {30'd0, ep0_nak_in, ep0_nak_out}, 32'd1);
      fw_pulse(1'b0, 1'b1, 1'b0, 1'b0);
      check("R7 clr out", {30'd0, ep0_nak_in, ep0_nak_out}, 32'd0);

      // R7: completion beats a same-cycle clear
      send_packet(2'b10, 1'b1, 4'd0, 8, 1'b1, 8'hC0, 1'b1);
      for (int i = 0; i < 8; i++) model[i] = 8'hC0 + 8'(i);
      check("R7 commit wins", {31'd0, ep0_nak_in}, 1);
      check_bank("R2 bank C0");

      // R8: sticky status and interrupt gating
      repeat (5) @(negedge clk);
      check("R8 sticky", {31'd0, stat_setup}, 1);
      check("R8 irq masked", {31'd0, irq}, 0);
      irq_en = 1'b1;
      #1;
      check("R8 irq on", {31'd0, irq}, 1);
      fw_pulse(1'b0, 1'b0, 1'b0, 1'b1);
      check("R8 w1c stat", {31'd0, stat_setup}, 0);
      check("R8 irq off", {31'd0, irq}, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule